// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Output Writes

This block is a register-mapped general-purpose I/O peripheral. It serves a parameterised number of bank slots, each up to 32 pins wide. A slot can be declared empty, so populated banks need not sit next to each other. Every bank holds an output latch, a direction register, an output-enable register and a sampled copy of its pad inputs. Pad inputs reach the sampled copy through a two-flop synchronizer.

Software changes output pins through two half-word registers per bank. Each one carries a 16-bit keep-mask in its upper half and 16 data bits in its lower half. Single pins can therefore be set or cleared in one write, with no read-modify-write. Bank 0 can declare pins that must always be outputs; their direction bits are held at 1.

Reads come back on `rd_data` in the clock cycle after the cycle where `rd_en` is high. In every other cycle `rd_data` is 0. Writes take effect at the clock edge where `wr_en` is high. Pad signals are flattened, with bank slot b taking bits `[32*b+31 : 32*b]`.

Top module: `banked_gpio`

## Requirements
- R1: A write to offset 8*b (low half) or 8*b+4 (high half) updates pins 15..0 or 31..16 of bank b. Each latch bit takes the matching data bit from `wr_data[15:0]` where its mask bit in `wr_data[31:16]` is 0. Where the mask bit is 1, the latch bit keeps its value.
- R2: A read of a masked data register returns the latch half-word in bits 15:0 and 0 in bits 31:16.
- R3: The direction register of bank b is at offset 0x204+0x40*b. It is written whole and reads back its value; a 1 marks the pin as an output.
- R4: The output-enable register of bank b is at offset 0x208+0x40*b. It is written whole and reads back its value.
- R5: `pad_oe` of a pin is 1 exactly when both its direction bit and its output-enable bit are 1. `pad_out` carries the pin's output latch bit. Pad outputs change only after a register write.
- R6: The read-only register at offset 0x60+4*b returns the pad inputs of bank b after a two-flop synchronizer. A pad change is not visible to a read sampled at the first clock edge after the change. It is visible to a read sampled at the third clock edge after the change.
- R7: The direction bits of bank 0 named in `FORCE_BANK0` (default pins 7 and 8, mask 0x180) always read 1 and ignore writes of 0.
- R8: Bits at or above a bank's pin count read 0, ignore writes and drive `pad_out` and `pad_oe` to 0. A slot with 0 pins reads 0 everywhere.
- R9: After reset, output latches, output-enable bits and direction bits are 0, except the forced direction bits, which are 1. `pad_oe` is 0 on all pins except those whose forced direction bit and output-enable bit are both 1.
- R10: Reads of unmapped or non-word-aligned addresses return 0. Writes to them, and writes to the input registers, change no state.
- R11: `rd_data` holds the read result for exactly the one cycle after `rd_en` and is 0 in every cycle that follows a cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, applied at the clock edge |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read result, valid in the cycle after `rd_en` |
| pad_in | input | 32*BANK_SLOTS | Pad input levels, 32 per slot |
| pad_out | output | 32*BANK_SLOTS | Pad output values |
| pad_oe | output | 32*BANK_SLOTS | Pad driver enables |

## Verification
The hardest behaviour to reach from the ports is the synchronizer delay on the input path. It can only be seen through a bus read whose own one-cycle latency overlaps the two flop stages. The stimulus changes `pad_in` on a falling edge and then issues a read at once; that read must still return the old level. It then lets one more edge pass, so the next read is sampled at the third edge, and expects the new level. The forced direction bits are reached by writing all zeros to bank 0's direction register. The test then checks both the read-back and the resulting `pad_oe`.

// File: rtl/banked_gpio_pkg.sv
package banked_gpio_pkg;

    localparam int unsigned PAD_W        = 32;
    localparam int unsigned HALF_W       = 16;
    localparam int unsigned PIN_CNT_W    = 6;
    localparam int unsigned DATA_STRIDE  = 8;
    localparam int unsigned INPUT_BASE   = 'h60;
    localparam int unsigned INPUT_STRIDE = 4;
    localparam int unsigned CTRL_BASE    = 'h200;
    localparam int unsigned CTRL_STRIDE  = 'h40;
    localparam int unsigned DIR_SUB      = 4;
    localparam int unsigned OE_SUB       = 8;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_DATA_LO,
        KIND_DATA_HI,
        KIND_INPUT,
        KIND_DIR,
        KIND_OE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] bank;
    } reg_sel_t;

    // Mask of the populated pins of a bank with the given pin count.
    function automatic logic [PAD_W-1:0] pin_mask(input int unsigned pins);
        if (pins >= PAD_W) return '1;
        return (32'd1 << pins) - 32'd1;
    endfunction

    // Map a byte address onto a register kind and bank slot.
    function automatic reg_sel_t decode_addr(input int unsigned a, input int unsigned slots);
        reg_sel_t    s;
        int unsigned off;
        s.kind = KIND_NONE;
        s.bank = '0;
        off    = 0;
        if ((a % 4) != 0) begin
            s.kind = KIND_NONE;
        end else if (a < DATA_STRIDE * slots) begin
            s.bank = 4'(a / DATA_STRIDE);
            s.kind = ((a % DATA_STRIDE) == 4) ? KIND_DATA_HI : KIND_DATA_LO;
        end else if (a >= INPUT_BASE && a < INPUT_BASE + INPUT_STRIDE * slots) begin
            s.bank = 4'((a - INPUT_BASE) / INPUT_STRIDE);
            s.kind = KIND_INPUT;
        end else if (a >= CTRL_BASE && a < CTRL_BASE + CTRL_STRIDE * slots) begin
            off    = a - CTRL_BASE;
            s.bank = 4'(off / CTRL_STRIDE);
            if ((off % CTRL_STRIDE) == DIR_SUB)     s.kind = KIND_DIR;
            else if ((off % CTRL_STRIDE) == OE_SUB) s.kind = KIND_OE;
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import banked_gpio_pkg::*;
#(
    parameter int          PINS      = 32,
    parameter logic [31:0] FORCE_OUT = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             wr_dir,
    input  logic             wr_oe,
    input  logic [PAD_W-1:0] wdata,
    input  logic [PAD_W-1:0] pad_in,
    output logic [PAD_W-1:0] latch_q,
    output logic [PAD_W-1:0] dir_q,
    output logic [PAD_W-1:0] oe_q,
    output logic [PAD_W-1:0] sample_q,
    output logic [PAD_W-1:0] pad_out,
    output logic [PAD_W-1:0] pad_oe
);

    localparam logic [PAD_W-1:0] VALID = pin_mask(PINS);
    localparam logic [PAD_W-1:0] FORCE = FORCE_OUT & VALID;

    logic [HALF_W-1:0] keep;
    logic [HALF_W-1:0] lo_next;
    logic [HALF_W-1:0] hi_next;

    always_comb begin
        keep    = wdata[PAD_W-1:HALF_W];
        lo_next = (latch_q[HALF_W-1:0]     & keep) | (wdata[HALF_W-1:0] & ~keep);
        hi_next = (latch_q[PAD_W-1:HALF_W] & keep) | (wdata[HALF_W-1:0] & ~keep);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= FORCE;
            oe_q    <= '0;
        end else begin
            if (wr_lo)  latch_q <= {latch_q[PAD_W-1:HALF_W], lo_next} & VALID;
            if (wr_hi)  latch_q <= {hi_next, latch_q[HALF_W-1:0]} & VALID;
            if (wr_dir) dir_q   <= (wdata | FORCE) & VALID;
            if (wr_oe)  oe_q    <= wdata & VALID;
        end
    end

    gpio_sync #(.WIDTH(PAD_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in & VALID),
        .q     (sample_q)
    );

    assign pad_oe  = dir_q & oe_q;
    assign pad_out = latch_q;

endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
    import banked_gpio_pkg::*;
#(
    parameter int                                BANK_SLOTS  = 5,
    parameter int                                ADDR_W      = 16,
    parameter logic [BANK_SLOTS*PIN_CNT_W-1:0]   BANK_PINS   = {6'd32, 6'd32, 6'd0, 6'd26, 6'd26},
    parameter logic [31:0]                       FORCE_BANK0 = 32'h0000_0180
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [31:0]                 wr_data,
    input  logic                        wr_en,
    input  logic                        rd_en,
    output logic [31:0]                 rd_data,
    input  logic [BANK_SLOTS*PAD_W-1:0] pad_in,
    output logic [BANK_SLOTS*PAD_W-1:0] pad_out,
    output logic [BANK_SLOTS*PAD_W-1:0] pad_oe
);

    reg_sel_t         sel;
    logic [PAD_W-1:0] latch_w  [BANK_SLOTS];
    logic [PAD_W-1:0] dir_w    [BANK_SLOTS];
    logic [PAD_W-1:0] oe_w     [BANK_SLOTS];
    logic [PAD_W-1:0] sample_w [BANK_SLOTS];
    logic [31:0]      rd_mux;

    assign sel = decode_addr(32'(addr), BANK_SLOTS);

    for (genvar b = 0; b < BANK_SLOTS; b++) begin : g_bank
        logic hit;
        assign hit = wr_en && (sel.bank == 4'(b));

        gpio_bank #(
            .PINS      (int'(BANK_PINS[b*PIN_CNT_W +: PIN_CNT_W])),
            .FORCE_OUT ((b == 0) ? FORCE_BANK0 : 32'h0)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (hit && sel.kind == KIND_DATA_LO),
            .wr_hi    (hit && sel.kind == KIND_DATA_HI),
            .wr_dir   (hit && sel.kind == KIND_DIR),
            .wr_oe    (hit && sel.kind == KIND_OE),
            .wdata    (wr_data),
            .pad_in   (pad_in[b*PAD_W +: PAD_W]),
            .latch_q  (latch_w[b]),
            .dir_q    (dir_w[b]),
            .oe_q     (oe_w[b]),
            .sample_q (sample_w[b]),
            .pad_out  (pad_out[b*PAD_W +: PAD_W]),
            .pad_oe   (pad_oe[b*PAD_W +: PAD_W])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < BANK_SLOTS; b++) begin
            if (sel.bank == 4'(b)) begin
                case (sel.kind)
                    KIND_DATA_LO: rd_mux = {16'h0, latch_w[b][HALF_W-1:0]};
                    KIND_DATA_HI: rd_mux = {16'h0, latch_w[b][PAD_W-1:HALF_W]};
                    KIND_INPUT:   rd_mux = sample_w[b];
                    KIND_DIR:     rd_mux = dir_w[b];
                    KIND_OE:      rd_mux = oe_w[b];
                    default:      rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_en ? rd_mux : '0;
    end

endmodule

// File: rtl/banked_gpio_chk.sv
module banked_gpio_chk
    import banked_gpio_pkg::*;
#(
    parameter int                              BANK_SLOTS  = 5,
    parameter int                              ADDR_W      = 16,
    parameter logic [BANK_SLOTS*PIN_CNT_W-1:0] BANK_PINS   = {6'd32, 6'd32, 6'd0, 6'd26, 6'd26},
    parameter logic [31:0]                     FORCE_BANK0 = 32'h0000_0180
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           addr,
    input logic                        wr_en,
    input logic                        rd_en,
    input logic [31:0]                 rd_data,
    input logic [BANK_SLOTS*PAD_W-1:0] pad_out,
    input logic [BANK_SLOTS*PAD_W-1:0] pad_oe
);

    logic [BANK_SLOTS*PAD_W-1:0] valid_all;

    for (genvar b = 0; b < BANK_SLOTS; b++) begin : g_valid
        assign valid_all[b*PAD_W +: PAD_W] = pin_mask(int'(BANK_PINS[b*PIN_CNT_W +: PIN_CNT_W]));
    end

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == 32'h0); // R11

    AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[1:0] != 2'b00) |=> rd_data == 32'h0); // R10

    AST_MASKED_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[1:0] == 2'b00 && int'(addr) < 8 * BANK_SLOTS) |=> rd_data[31:16] == 16'h0); // R2

    AST_FORCED_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(addr) == 'h204) |=> (rd_data & FORCE_BANK0 & valid_all[31:0]) == (FORCE_BANK0 & valid_all[31:0])); // R7

    AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pad_out) && $stable(pad_oe))); // R5

    AST_UNPOPULATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out | pad_oe) & ~valid_all) == '0); // R8

endmodule

bind banked_gpio banked_gpio_chk #(
    .BANK_SLOTS  (BANK_SLOTS),
    .ADDR_W      (ADDR_W),
    .BANK_PINS   (BANK_PINS),
    .FORCE_BANK0 (FORCE_BANK0)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
);

// File: tb/test_banked_gpio.sv
`timescale 1ns/1ps
module test_banked_gpio;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  addr = '0;
    logic [31:0]  wr_data = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [31:0]  rd_data;
    logic [159:0] pad_in = '0;
    logic [159:0] pad_out;
    logic [159:0] pad_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    banked_gpio i_banked_gpio (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    // All bus tasks start and end just after a falling edge.
    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R9 pad_oe after reset", pad_oe[31:0], 32'h0);
        chk("R9 pad_out after reset", pad_out[31:0], 32'h0);
        bus_read(16'h0204, v); chk("R9/R7 dir0 reset", v, 32'h0000_0180);
        bus_read(16'h0208, v); chk("R9 oe0 reset", v, 32'h0);
        bus_read(16'h0000, v); chk("R9 latch reset", v, 32'h0);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        bus_write(16'h0000, 32'h0000_A5A5);
        bus_read(16'h0000, v); chk("R1 full load lo0", v, 32'h0000_A5A5);
        bus_write(16'h0000, 32'hFF00_0033);
        bus_read(16'h0000, v); chk("R1/R2 keep upper byte lo0", v, 32'h0000_A533);
        bus_write(16'h001C, 32'h0000_FFFF);
        bus_read(16'h001C, v); chk("R1 hi3 load", v, 32'h0000_FFFF);
        bus_read(16'h0018, v); chk("R1 lo3 untouched", v, 32'h0);
        bus_write(16'h0024, 32'h00FF_1234);
        bus_read(16'h0024, v); chk("R1 hi4 keep low byte", v, 32'h0000_1200);
        bus_write(16'h0004, 32'h0000_FFFF);
        bus_read(16'h0004, v); chk("R8 hi0 above pin 25", v, 32'h0000_03FF);
    endtask

    task automatic t_pads();
        logic [31:0] v;
        bus_write(16'h0204, 32'h0000_000F);
        bus_read(16'h0204, v); chk("R3 dir0 readback", v, 32'h0000_018F);
        bus_write(16'h0208, 32'h0000_00FF);
        bus_read(16'h0208, v); chk("R4 oe0 readback", v, 32'h0000_00FF);
        chk("R5 pad_oe bank0", pad_oe[31:0], 32'h0000_008F);
        chk("R5 pad_out bank0", pad_out[31:0], 32'h03FF_A533);
        chk("R5 pad_out bank3", pad_out[127:96], 32'hFFFF_0000);
        chk("R5 pad_out bank4", pad_out[159:128], 32'h1200_0000);
        bus_write(16'h0248, 32'hFFFF_FFFF);
        chk("R5 oe without dir bank1", pad_oe[63:32], 32'h0);
        bus_write(16'h0244, 32'hFFFF_FFFF);
        bus_read(16'h0244, v); chk("R3/R8 dir1 readback", v, 32'h03FF_FFFF);
        chk("R5 oe with dir bank1", pad_oe[63:32], 32'h03FF_FFFF);
    endtask

    task automatic t_forced();
        logic [31:0] v;
        bus_write(16'h0204, 32'h0);
        bus_read(16'h0204, v); chk("R7 forced dir bits", v, 32'h0000_0180);
        chk("R7 forced pin drives", pad_oe[31:0], 32'h0000_0080);
    endtask

    task automatic t_input();
        logic [31:0] v;
        pad_in[31:0]    = 32'hFFFF_FFFF;
        pad_in[63:32]   = 32'h1234_5678;
        pad_in[95:64]   = 32'hFFFF_FFFF;
        pad_in[127:96]  = 32'hDEAD_BEEF;
        bus_read(16'h0060, v); chk("R6 not yet visible", v, 32'h0);
        @(posedge clk);
        @(negedge clk);
        bus_read(16'h0060, v); chk("R6 bank0 input", v, 32'h03FF_FFFF);
        bus_read(16'h0064, v); chk("R6/R8 bank1 input", v, 32'h0234_5678);
        bus_read(16'h006C, v); chk("R6 bank3 input", v, 32'hDEAD_BEEF);
        bus_read(16'h0068, v); chk("R8 empty slot input", v, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        bus_write(16'h0060, 32'h0);
        bus_read(16'h0060, v); chk("R10 input reg write ignored", v, 32'h03FF_FFFF);
        bus_write(16'h0284, 32'hFFFF_FFFF);
        bus_write(16'h0288, 32'hFFFF_FFFF);
        bus_read(16'h0288, v); chk("R8 empty slot oe", v, 32'h0);
        chk("R8 empty slot pads", pad_oe[95:64] | pad_out[95:64], 32'h0);
        bus_read(16'h0300, v); chk("R10 unmapped read", v, 32'h0);
        bus_read(16'h0002, v); chk("R10 misaligned read", v, 32'h0);
        bus_write(16'h0001, 32'h0000_FFFF);
        bus_read(16'h0000, v); chk("R10 misaligned write ignored", v, 32'h0000_A533);
    endtask

    task automatic t_latency();
        logic [31:0] v;
        bus_read(16'h0204, v); chk("R11 read result", v, 32'h0000_0180);
        @(posedge clk);
        @(negedge clk);
        chk("R11 idle cycle zero", rd_data, 32'h0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_pads();
        t_forced();
        t_input();
        t_ignored();
        t_latency();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule